// File: doc/BRIEF.md
# Serial Tuning Word Loader

This block takes a synthesizer control word from a three-wire serial port made of an enable line, a serial clock and a data line. It delivers the word as three parallel holding registers: a 4-bit band-switch field, a 10-bit main divider count M and a 5-bit swallow count S. A one-cycle strobe accompanies each register update, so a downstream divider or band driver can pick up new settings without polling.

The serial lines are asynchronous to the block's system clock. Each line passes through a two-flop synchronizer, and falling edges of the serial clock are detected in the system domain. A bit is taken on each such edge while enable is high. The band field is committed as soon as its four bits are in. The divider counts are committed together only when the whole 19-bit word has arrived. A frame cut short by enable going low therefore updates only the band field.

Top module: `serial_tuning_loader`

## Requirements
- R1: After reset, band_o is 0, main_o is 32, swal_o is 0 and both strobes are low.
- R2: A bit is accepted only on a falling edge of the serial clock while enable is high. Falling edges seen while enable is low change no output.
- R3: The band register loads at the 4th accepted falling edge of a frame. The first bit received lands in band_o[3] and the fourth in band_o[0].
- R4: Bits 5 to 14 of the frame form main_o with the first of them as bit 9. Bits 15 to 19 form swal_o with the first of them as bit 4.
- R5: main_o and swal_o change only together, and only at the 19th accepted falling edge of a frame.
- R6: If enable drops after the band bits but before the 19th edge, the new band value stays in place and main_o and swal_o keep their previous values.
- R7: Falling edges after the 19th within the same frame change no output.
- R8: band_upd_o is high for exactly one cycle each time the band register loads. div_upd_o is high for exactly one cycle each time M and S load. The two strobes are never high together.
- R9: A rising edge of enable restarts the frame. Bits taken before it are discarded and the next bit counts as bit 1.
- R10: An output update appears on the third rising system clock edge after the serial clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk_i | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat_i | input | 1 | Serial data, most significant bit of each field first |
| ser_en_i | input | 1 | Frame enable, active high |
| band_o | output | 4 | Band-switch holding register |
| main_o | output | 10 | Main divider count M |
| swal_o | output | 5 | Swallow count S |
| band_upd_o | output | 1 | One-cycle pulse when band_o loads |
| div_upd_o | output | 1 | One-cycle pulse when main_o and swal_o load |

## Verification
The assertions check, on every cycle, these properties:
- the bit counter never passes the frame length;
- the band and divider registers change only in a cycle marked by their strobe;
- each strobe coincides with the counter at the 4th or 19th bit;
- the strobes never overlap;
- a detected serial falling edge lasts one cycle.

Other behaviour depends on the sequence of a whole frame, so only the bench's scenarios can show it. This covers bit order into each field, short frames keeping the band value, extra pulses being ignored, enable-low edges being ignored, restarts on a fresh enable, and the exact three-edge latency. The bench checks these against a cycle-by-cycle model.

// File: rtl/stl_pkg.sv
package stl_pkg;
  localparam int BAND_W      = 4;
  localparam int MAIN_W      = 10;
  localparam int SWAL_W      = 5;
  localparam int MAIN_RST    = 32;
  localparam int SYNC_STAGES = 2;

  // order of the synchronized serial lines inside one vector
  localparam int IDX_CLK = 2;
  localparam int IDX_EN  = 1;
  localparam int IDX_DAT = 0;
endpackage

// File: rtl/stl_sync.sv
module stl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
      end else begin
        stage_q[g] <= stage_d[g];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/stl_edge.sv
module stl_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic en_i,
  output logic sclk_fall_o,
  output logic en_rise_o
);
  logic sclk_q, sclk_d;
  logic en_q, en_d;

  always_comb begin
    sclk_d = sclk_i;
    en_d   = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
      en_q   <= en_d;
    end
  end

  assign sclk_fall_o = sclk_q & ~sclk_i;
  assign en_rise_o   = ~en_q & en_i;

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall_o |=> !sclk_fall_o); // R2
  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise_o |=> !en_rise_o); // R9
endmodule

// File: rtl/stl_frame.sv
module stl_frame #(
  parameter int BAND_W   = 4,
  parameter int MAIN_W   = 10,
  parameter int SWAL_W   = 5,
  parameter int MAIN_RST = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_fall_i,
  input  logic              en_rise_i,
  input  logic              en_i,
  input  logic              dat_i,
  output logic [BAND_W-1:0] band_o,
  output logic [MAIN_W-1:0] main_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic              band_upd_o,
  output logic              div_upd_o
);
  localparam int FRAME_W = BAND_W + MAIN_W + SWAL_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] BAND_LAST  = CNT_W'(BAND_W - 1);
  localparam logic [CNT_W-1:0] BAND_CNT   = CNT_W'(BAND_W);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FRAME_CNT  = CNT_W'(FRAME_W);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-2:0] sh_q, sh_d;
  logic [FRAME_W-1:0] word;
  logic [BAND_W-1:0]  band_q, band_d;
  logic [MAIN_W-1:0]  main_q, main_d;
  logic [SWAL_W-1:0]  swal_q, swal_d;
  logic               bstb_q, bstb_d;
  logic               dstb_q, dstb_d;
  logic               take;

  assign word = {sh_q, dat_i};
  assign take = sclk_fall_i & en_i & (cnt_q < FRAME_CNT);

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    band_d = band_q;
    main_d = main_q;
    swal_d = swal_q;
    bstb_d = 1'b0;
    dstb_d = 1'b0;
    if (en_rise_i) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (take) begin
      cnt_d = cnt_q + CNT_W'(1);
      sh_d  = word[FRAME_W-2:0];
      if (cnt_q == BAND_LAST) begin
        band_d = word[BAND_W-1:0];
        bstb_d = 1'b1;
      end
      if (cnt_q == FRAME_LAST) begin
        main_d = word[SWAL_W +: MAIN_W];
        swal_d = word[SWAL_W-1:0];
        dstb_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      band_q <= '0;
      main_q <= MAIN_W'(MAIN_RST);
      swal_q <= '0;
      bstb_q <= 1'b0;
      dstb_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      band_q <= band_d;
      main_q <= main_d;
      swal_q <= swal_d;
      bstb_q <= bstb_d;
      dstb_q <= dstb_d;
    end
  end

  assign band_o     = band_q;
  assign main_o     = main_q;
  assign swal_o     = swal_q;
  assign band_upd_o = bstb_q;
  assign div_upd_o  = dstb_q;

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FRAME_CNT); // R7
  AST_BAND_AT_FOURTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bstb_q |-> cnt_q == BAND_CNT); // R3
  AST_DIV_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstb_q |-> cnt_q == FRAME_CNT); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bstb_q && dstb_q)); // R8
  AST_BAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    !bstb_q |-> $stable(band_q)); // R6
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    !dstb_q |-> ($stable(main_q) && $stable(swal_q))); // R5
endmodule

// File: rtl/serial_tuning_loader.sv
module serial_tuning_loader
  import stl_pkg::*;
#(
  parameter int P_BAND_W   = BAND_W,
  parameter int P_MAIN_W   = MAIN_W,
  parameter int P_SWAL_W   = SWAL_W,
  parameter int P_MAIN_RST = MAIN_RST,
  parameter int P_SYNC     = SYNC_STAGES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ser_clk_i,
  input  logic                ser_dat_i,
  input  logic                ser_en_i,
  output logic [P_BAND_W-1:0] band_o,
  output logic [P_MAIN_W-1:0] main_o,
  output logic [P_SWAL_W-1:0] swal_o,
  output logic                band_upd_o,
  output logic                div_upd_o
);
  logic [2:0] raw, synced;
  logic       sclk_fall, en_rise;

  always_comb begin
    raw          = '0;
    raw[IDX_CLK] = ser_clk_i;
    raw[IDX_EN]  = ser_en_i;
    raw[IDX_DAT] = ser_dat_i;
  end

  stl_sync #(.W(3), .STAGES(P_SYNC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (raw),
    .sync_o  (synced)
  );

  stl_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (synced[IDX_CLK]),
    .en_i        (synced[IDX_EN]),
    .sclk_fall_o (sclk_fall),
    .en_rise_o   (en_rise)
  );

  stl_frame #(
    .BAND_W   (P_BAND_W),
    .MAIN_W   (P_MAIN_W),
    .SWAL_W   (P_SWAL_W),
    .MAIN_RST (P_MAIN_RST)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_fall_i (sclk_fall),
    .en_rise_i   (en_rise),
    .en_i        (synced[IDX_EN]),
    .dat_i       (synced[IDX_DAT]),
    .band_o      (band_o),
    .main_o      (main_o),
    .swal_o      (swal_o),
    .band_upd_o  (band_upd_o),
    .div_upd_o   (div_upd_o)
  );
endmodule

// File: tb/tb_serial_tuning_loader.sv
module tb_serial_tuning_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_clk = 1'b0, s_dat = 1'b0, s_en = 1'b0;
  logic [3:0] band;
  logic [9:0] mval;
  logic [4:0] sval;
  logic bupd, dupd;

  int checks = 0, errors = 0;
  int bpulses = 0, dpulses = 0, long_pulse = 0;
  logic bupd_prev = 1'b0, dupd_prev = 1'b0;

  // reference model state
  int m_cnt = 0;
  int m_word = 0;
  int m_band = 0, m_main = 32, m_swal = 0;
  int m_bstb = 0, m_dstb = 0;
  logic [2:0] h1 = '0, h2 = '0, h3 = '0;  // {clk, en, dat}

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_tuning_loader dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(s_clk), .ser_dat_i(s_dat),
    .ser_en_i(s_en), .band_o(band), .main_o(mval), .swal_o(sval),
    .band_upd_o(bupd), .div_upd_o(dupd)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model: an input change shows at the outputs three edges later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_word = 0; m_band = 0; m_main = 32; m_swal = 0;
      m_bstb = 0; m_dstb = 0; h1 = '0; h2 = '0; h3 = '0;
    end else begin
      m_bstb = 0; m_dstb = 0;
      if (!h3[1] && h2[1]) begin
        m_cnt = 0; m_word = 0;
      end else if (h3[2] && !h2[2] && h2[1] && m_cnt < 19) begin
        m_word = (m_word << 1) | int'(h2[0]);
        m_cnt++;
        if (m_cnt == 4) begin m_band = m_word & 15; m_bstb = 1; end
        if (m_cnt == 19) begin
          m_main = (m_word >> 5) & 1023; m_swal = m_word & 31; m_dstb = 1;
        end
      end
      h3 = h2; h2 = h1; h1 = {s_clk, s_en, s_dat};
    end
  end

  // per-cycle comparison and strobe bookkeeping, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10 band cycle", int'(band), m_band);
      check("R10 main cycle", int'(mval), m_main);
      check("R10 swal cycle", int'(sval), m_swal);
      check("R8 band strobe cycle", int'(bupd), m_bstb);
      check("R8 div strobe cycle", int'(dupd), m_dstb);
      if (bupd) bpulses++;
      if (dupd) dpulses++;
      if ((bupd && bupd_prev) || (dupd && dupd_prev)) long_pulse++;
      bupd_prev = bupd; dupd_prev = dupd;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    s_dat = b; s_clk = 1'b1; wait_clk(HOLD);
    s_clk = 1'b0; wait_clk(HOLD);
  endtask

  task automatic send_frame(input int nbits, input logic [31:0] w, input bit drop);
    s_en = 1'b1; wait_clk(HOLD);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
    if (drop) begin s_en = 1'b0; wait_clk(HOLD * 2); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [18:0] w1, w2, w3;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset values
    check("R1 band", int'(band), 0);
    check("R1 main", int'(mval), 32);
    check("R1 swal", int'(sval), 0);
    check("R1 strobes", int'(bupd | dupd), 0);

    // full frame: band A, M 0x2B5, S 0x13
    w1 = {4'hA, 10'h2B5, 5'h13};
    bpulses = 0; dpulses = 0;
    send_frame(19, {13'd0, w1}, 1'b1);
    check("R3 band order", int'(band), 4'hA);
    check("R4 main order", int'(mval), 10'h2B5);
    check("R4 swal order", int'(sval), 5'h13);
    check("R8 band pulses", bpulses, 1);
    check("R8 div pulses", dpulses, 1);
    check("R8 single width", long_pulse, 0);

    // short frame: 10 bits, band 5 stays, divider unchanged
    w2 = {4'h5, 10'h0F0, 5'h07};
    send_frame(10, {13'd0, w2} >> 9, 1'b1);
    check("R6 band kept", int'(band), 5);
    check("R6 main kept", int'(mval), 10'h2B5);
    check("R6 swal kept", int'(sval), 5'h13);

    // 23 pulses: the last four change nothing
    w3 = {4'h3, 10'h155, 5'h0A};
    send_frame(23, {9'd0, w3, 4'hF}, 1'b1);
    check("R7 band", int'(band), 3);
    check("R7 main", int'(mval), 10'h155);
    check("R7 swal", int'(sval), 5'h0A);

    // falling edges with enable low are ignored
    for (int i = 0; i < 25; i++) send_bit(1'b1);
    wait_clk(HOLD);
    check("R2 band", int'(band), 3);
    check("R2 main", int'(mval), 10'h155);
    check("R2 swal", int'(sval), 5'h0A);

    // restart: 6 bits, enable drop, then full frame counted afresh
    send_frame(6, 32'h3F, 1'b1);
    check("R9 partial band", int'(band), 15);
    bpulses = 0; dpulses = 0;
    send_frame(19, {13'd0, w2}, 1'b1);
    check("R9 band", int'(band), 5);
    check("R9 main", int'(mval), 10'h0F0);
    check("R9 swal", int'(sval), 5'h07);
    check("R8 pulses restart", bpulses + dpulses, 2);

    wait_clk(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule